// File: doc/BRIEF.md
# Mode-Switched Interval / Event / PWM Timer

A single 16-bit timer channel that runs in one of three ways: as an interval timer that counts down on a synchronous tick strobe, as an event counter that counts down on a synchronous event strobe, or as a pulse width modulator that drives one output pin. Software sets it up through simple write strobes: one loads the reload value, the other writes a 2-bit mode field together with a run flag. A sticky interrupt request bit collects the channel's events and is cleared by a dedicated strobe.

The block handles the side effects of switching modes and of halting. Selecting the modulator mode raises the interrupt request by itself. Halting while the output is high pulls the output low and raises the request. Halting while the output is low leaves both untouched. In modulator mode the period is fixed at 2^16-1 ticks, and the high time at the start of each period equals the reload value latched at that period's start.

Top module: `pwm_mode_timer`

## Requirements
- R1: After reset the mode is interval timer (code 00), the run flag is clear, `count_out` is 0, `pwm_out` is 0 and `irq` is 0.
- R2: A control write with `ctrl_mode` = 10 (modulator) while the stored mode is any other code sets `irq` at that same clock edge, whether or not the run flag is set.
- R3: An `irq_clr` strobe clears `irq`, and `irq` then stays 0 until a new set condition. A set condition in the same cycle as `irq_clr` wins.
- R4: In mode 00 (and in code 11, which behaves like 00), a control write that starts the channel, or that changes the mode while it runs, loads the counter with the stored reload value. Each later `tick` decrements it. A `tick` at count 0 reloads it instead and sets `irq`. A reload write in the same cycle as a start takes effect only at the next reload.
- R5: In mode 01 only `evt` strobes move the counter, with the same reload and underflow rules as R4. `tick` has no effect.
- R6: In mode 10, `count_out` is the phase, which starts at 0 on a start, advances by one on each `tick`, and wraps from 65534 to 0. `pwm_out` is 1 exactly while the phase is below the latched duty value N, so a reload value of 0 keeps it low for the whole period.
- R7: Every falling edge of `pwm_out` sets `irq` at the same edge.
- R8: A reload write during modulator operation changes the duty only at the next wrap to phase 0. The current period keeps its old high time.
- R9: Clearing the run flag while `pwm_out` is 1 drops `pwm_out` to 0 and sets `irq` at that edge, and the counter then holds its value.
- R10: Clearing the run flag while `pwm_out` is 0 leaves it at 0, does not set `irq`, and freezes the counter.
- R11: `pwm_out` is 1 only while the mode is 10 and the run flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_ctrl | input | 1 | Write strobe for mode and run flag |
| wdata | input | 16 | Reload value written by `wr_reload` |
| ctrl_mode | input | 2 | Mode written by `wr_ctrl`: 00 timer, 01 event, 10 modulator, 11 as timer |
| ctrl_start | input | 1 | Run flag written by `wr_ctrl` |
| irq_clr | input | 1 | Clears the interrupt request |
| tick | input | 1 | Count strobe for timer and modulator modes |
| evt | input | 1 | Count strobe for event mode |
| count_out | output | 16 | Counter value, or phase in modulator mode |
| pwm_out | output | 1 | Modulator output pin |
| irq | output | 1 | Sticky interrupt request |

## Verification
Every result is due at the clock edge that samples its strobe. Control and reload writes, tick and event strobes, clears, the output level and the interrupt bit all land in registers at that one edge, with no extra pipeline stage. The bench therefore changes inputs between edges and compares each output 1 ns after the edge that consumed the stimulus. Its reference values come from a per-cycle model that follows the reload, underflow and set-over-clear rules. Modulator checks sample at exact phases, including the last phase before the wrap and the first phases after it, so that a duty change is seen at the right period boundary.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_PWM   = 2'b10,
    MODE_ALT   = 2'b11
  } pmt_mode_e;
endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_reload,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   ctrl_mode,
  input  logic         ctrl_start,
  output logic [W-1:0] reload_q,
  output pmt_mode_e    mode_q,
  output logic         run_q,
  output pmt_mode_e    mode_nxt,
  output logic         run_nxt,
  output logic         restart,
  output logic         pwm_enter
);
  always_comb begin
    mode_nxt = wr_ctrl ? pmt_mode_e'(ctrl_mode) : mode_q;
    run_nxt  = wr_ctrl ? ctrl_start : run_q;
  end

  // start from halt, or a mode change while running, restarts the counter
  assign restart   = wr_ctrl && ctrl_start && (!run_q || (mode_nxt != mode_q));
  assign pwm_enter = wr_ctrl && (mode_nxt == MODE_PWM) && (mode_q != MODE_PWM);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      mode_q   <= MODE_TIMER;
      run_q    <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      mode_q <= mode_nxt;
      run_q  <= run_nxt;
    end
  end

  assert_reset_mode_R1: assert property (@(posedge clk) rst |=> (mode_q == MODE_TIMER) && !run_q);
endmodule

// File: rtl/pmt_core.sv
module pmt_core
  import pmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  pmt_mode_e    mode_q,
  input  logic         run_q,
  input  pmt_mode_e    mode_nxt,
  input  logic         run_nxt,
  input  logic         restart,
  input  logic [W-1:0] reload_q,
  input  logic         tick,
  input  logic         evt,
  output logic [W-1:0] cnt_q,
  output logic         out_q,
  output logic         underflow,
  output logic         fall
);
  // last phase of a period of 2^W-1 ticks
  localparam logic [W-1:0] LAST_PHASE = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] duty_q, cnt_n, duty_n, phase_n;
  logic         out_n, step, is_pwm, last;

  assign is_pwm = (mode_q == MODE_PWM);
  assign step   = run_q && run_nxt && !restart && ((mode_q == MODE_EVENT) ? evt : tick);
  assign last   = (cnt_q == LAST_PHASE);
  assign phase_n = last ? '0 : cnt_q + 1'b1;

  always_comb begin
    cnt_n     = cnt_q;
    duty_n    = duty_q;
    out_n     = out_q;
    underflow = 1'b0;
    if (restart) begin
      cnt_n  = (mode_nxt == MODE_PWM) ? '0 : reload_q;
      duty_n = reload_q;
      out_n  = (mode_nxt == MODE_PWM) && (reload_q != '0);
    end else if (!run_nxt) begin
      out_n = 1'b0;
    end else if (step) begin
      if (is_pwm) begin
        cnt_n  = phase_n;
        if (last) duty_n = reload_q;
        out_n  = phase_n < (last ? reload_q : duty_q);
      end else begin
        out_n = 1'b0;
        if (cnt_q == '0) begin
          cnt_n     = reload_q;
          underflow = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  assign fall = out_q && !out_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      duty_q <= duty_n;
      out_q  <= out_n;
    end
  end

  // R9 / R10: a halt freezes the counter
  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (run_q && !run_nxt) |=> $stable(cnt_q));
  assert_halt_high_low_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && is_pwm && out_q && !run_nxt) |=> !out_q);
  assert_out_pwm_only_R11: assert property (@(posedge clk) disable iff (rst)
    out_q |-> (is_pwm && run_q));
  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (rst)
    (restart && mode_nxt == MODE_PWM && reload_q == '0) |=> !out_q);
endmodule

// File: rtl/pmt_irq.sv
module pmt_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)      irq_q <= 1'b0;
    else if (set) irq_q <= 1'b1;
    else if (clr) irq_q <= 1'b0;
  end

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst) set |=> irq_q);
  assert_clear_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!set && (clr || !irq_q)) |=> !irq_q);
endmodule

// File: rtl/pwm_mode_timer.sv
module pwm_mode_timer
  import pmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_reload,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   ctrl_mode,
  input  logic         ctrl_start,
  input  logic         irq_clr,
  input  logic         tick,
  input  logic         evt,
  output logic [W-1:0] count_out,
  output logic         pwm_out,
  output logic         irq
);
  logic [W-1:0] reload_q;
  pmt_mode_e    mode_q, mode_nxt;
  logic         run_q, run_nxt, restart, pwm_enter, underflow, fall, irq_set;

  pmt_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_reload(wr_reload), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .ctrl_mode(ctrl_mode), .ctrl_start(ctrl_start), .reload_q(reload_q),
    .mode_q(mode_q), .run_q(run_q), .mode_nxt(mode_nxt), .run_nxt(run_nxt),
    .restart(restart), .pwm_enter(pwm_enter)
  );

  pmt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .mode_q(mode_q), .run_q(run_q), .mode_nxt(mode_nxt),
    .run_nxt(run_nxt), .restart(restart), .reload_q(reload_q), .tick(tick), .evt(evt),
    .cnt_q(count_out), .out_q(pwm_out), .underflow(underflow), .fall(fall)
  );

  assign irq_set = underflow | fall | pwm_enter;

  pmt_irq u_irq (.clk(clk), .rst(rst), .set(irq_set), .clr(irq_clr), .irq_q(irq));

  assert_enter_irq_R2: assert property (@(posedge clk) disable iff (rst) pwm_enter |=> irq);
  assert_fall_irq_R7: assert property (@(posedge clk) disable iff (rst) $fell(pwm_out) |-> irq);
endmodule

// File: tb/test_pwm_mode_timer.sv
module test_pwm_mode_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_reload = 0, wr_ctrl = 0, ctrl_start = 0, irq_clr = 0, tick = 0, evt = 0;
  logic [15:0] wdata = '0;
  logic [1:0]  ctrl_mode = '0;
  logic [15:0] count_out;
  logic        pwm_out, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_mode_timer i_pwm_mode_timer (
    .clk(clk), .rst(rst), .wr_reload(wr_reload), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .ctrl_mode(ctrl_mode), .ctrl_start(ctrl_start), .irq_clr(irq_clr), .tick(tick),
    .evt(evt), .count_out(count_out), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock edge, then settle; strobes are cleared afterwards
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_strobes();
    wr_reload = 0; wr_ctrl = 0; irq_clr = 0; tick = 0; evt = 0;
  endtask

  task automatic wr_rel(input logic [15:0] v);
    wdata = v; wr_reload = 1; cyc(); clear_strobes();
  endtask

  task automatic wr_ctl(input logic [1:0] m, input logic s);
    ctrl_mode = m; ctrl_start = s; wr_ctrl = 1; cyc(); clear_strobes();
  endtask

  task automatic clr_irq();
    irq_clr = 1; cyc(); clear_strobes();
  endtask

  function automatic logic exp_out(input int phase, input int n);
    return phase < n;
  endfunction

  // randomized interval / event run against a requirement-level model
  task automatic run_counter(input logic [1:0] m, input int cycles);
    int rel, cnt;
    bit ir;
    string tag;
    tag = (m == 2'b01) ? "R5" : "R4";
    rel = $urandom % 8;
    wr_rel(16'(rel));
    clr_irq();
    wr_ctl(m, 1'b1);
    cnt = rel; ir = 0;
    chk({tag, " start load"}, count_out, cnt);
    for (int i = 0; i < cycles; i++) begin
      bit t, e, c, w, st, set;
      int nrel;
      t = 1'($urandom % 2); e = 1'($urandom % 2);
      c = ($urandom % 6) == 0; w = ($urandom % 10) == 0;
      nrel = $urandom % 8;
      tick = t; evt = e; irq_clr = c; wr_reload = w; wdata = 16'(nrel);
      st = (m == 2'b01) ? e : t;
      set = 0;
      if (st) begin
        if (cnt == 0) begin cnt = rel; set = 1; end
        else cnt = cnt - 1;
      end
      if (set) ir = 1; else if (c) ir = 0;
      if (w) rel = nrel;
      cyc(); clear_strobes();
      chk({tag, " count"}, count_out, cnt);
      chk({tag, "/R3 irq"}, irq, ir);
      chk("R11 out low", pwm_out, 0);
    end
    wr_ctl(m, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst = 0;
    chk("R1 count", count_out, 0);
    chk("R1 out", pwm_out, 0);
    chk("R1 irq", irq, 0);
    tick = 1; cyc(); clear_strobes();
    chk("R1 stopped", count_out, 0);

    // R2: select modulator from reset state, stopped
    wr_ctl(2'b10, 1'b0);
    chk("R2 enter from reset", irq, 1);
    clr_irq();
    chk("R3 cleared", irq, 0);
    repeat (3) cyc();
    chk("R3 stays clear", irq, 0);

    // R3: set wins over clear (enter modulator from timer while clearing)
    wr_ctl(2'b00, 1'b0);
    irq_clr = 1; wr_ctl(2'b10, 1'b0);
    chk("R3 set wins", irq, 1);
    wr_ctl(2'b01, 1'b0);
    clr_irq();
    wr_ctl(2'b10, 1'b0);
    chk("R2 enter from event", irq, 1);
    clr_irq();

    // directed timer underflow: reload 2, ticks
    wr_ctl(2'b00, 1'b0);
    wr_rel(16'd2);
    wr_ctl(2'b00, 1'b1);
    chk("R4 load", count_out, 2);
    tick = 1; cyc(); cyc();
    chk("R4 decrement", count_out, 0);
    chk("R4 no irq yet", irq, 0);
    cyc(); clear_strobes();
    chk("R4 reload", count_out, 2);
    chk("R4 underflow irq", irq, 1);
    evt = 1; cyc(); clear_strobes();
    chk("R4 evt ignored", count_out, 2);
    wr_ctl(2'b00, 1'b0);
    clr_irq();

    // event mode ignores tick
    wr_rel(16'd4);
    wr_ctl(2'b01, 1'b1);
    tick = 1; repeat (3) cyc(); clear_strobes();
    chk("R5 tick ignored", count_out, 4);
    evt = 1; cyc(); clear_strobes();
    chk("R5 evt counts", count_out, 3);
    wr_ctl(2'b01, 1'b0);

    run_counter(2'b00, 300);
    run_counter(2'b01, 300);
    run_counter(2'b11, 200);
    clr_irq();

    // zero duty
    wr_rel(16'd0);
    wr_ctl(2'b10, 1'b1);
    clr_irq();
    tick = 1;
    for (int k = 0; k < 6; k++) begin
      cyc();
      chk("R6 zero duty low", pwm_out, 0);
    end
    clear_strobes();
    chk("R6 zero duty no irq", irq, 0);
    wr_ctl(2'b10, 1'b0);
    chk("R10 stop low no irq", irq, 0);

    // stop while high
    wr_rel(16'd10);
    wr_ctl(2'b10, 1'b1);
    chk("R6 high at phase 0", pwm_out, 1);
    tick = 1; cyc(); cyc(); clear_strobes();
    chk("R6 phase", count_out, 2);
    chk("R6 still high", pwm_out, 1);
    chk("R9 irq before stop", irq, 0);
    tick = 1; wr_ctl(2'b10, 1'b0);
    chk("R9 out dropped", pwm_out, 0);
    chk("R9 irq set", irq, 1);
    chk("R9 counter halted", count_out, 2);
    tick = 1; repeat (4) cyc(); clear_strobes();
    chk("R9 counter frozen", count_out, 2);
    chk("R11 out low stopped", pwm_out, 0);
    clr_irq();

    // stop while low
    wr_rel(16'd2);
    wr_ctl(2'b10, 1'b1);
    tick = 1; cyc();
    chk("R6 high phase 1", pwm_out, 1);
    cyc();
    chk("R6 low phase 2", pwm_out, 0);
    chk("R7 fall irq", irq, 1);
    clear_strobes();
    clr_irq();
    tick = 1; repeat (3) cyc(); clear_strobes();
    chk("R6 phase 5", count_out, 5);
    tick = 1; wr_ctl(2'b10, 1'b0);
    chk("R10 out stays low", pwm_out, 0);
    chk("R10 no irq", irq, 0);
    chk("R10 counter halted", count_out, 5);
    tick = 1; repeat (3) cyc(); clear_strobes();
    chk("R10 counter frozen", count_out, 5);

    // full period with mid-period duty change
    begin
      int ph;
      bit bad;
      wr_rel(16'd3);
      wr_ctl(2'b10, 1'b1);
      clr_irq();
      ph = 0;
      tick = 1;
      for (int k = 1; k <= 3; k++) begin
        cyc(); ph++;
        chk("R6 duty 3", pwm_out, exp_out(ph, 3));
      end
      chk("R7 fall at phase 3", irq, 1);
      wdata = 16'd5; wr_reload = 1; cyc(); ph++; wr_reload = 0;
      bad = 0;
      while (ph < 65534) begin
        cyc(); ph++;
        if (pwm_out !== 1'b0) bad = 1;
      end
      chk("R8 old duty kept", bad, 0);
      chk("R6 last phase", count_out, 65534);
      cyc(); ph = 0;
      chk("R6 wrap", count_out, 0);
      chk("R8 new duty at wrap", pwm_out, 1);
      for (int k = 1; k <= 6; k++) begin
        cyc(); ph++;
        chk("R8 duty 5", pwm_out, exp_out(ph, 5));
      end
      clear_strobes();
      wr_ctl(2'b00, 1'b1);
      chk("R11 out low after mode change", pwm_out, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule